// File: doc/BRIEF.md
# Parallel ROM Socket Emulator

This block stands in for a socketed parallel read-only memory on an older processor board. The socket offers only an address bus, an active-low output enable and a data bus, which is 8 or 16 bits wide. It carries no write strobe, and none of these signals is related to the block's own clock. The block runs from a faster local clock and brings the socket signals in through two-stage synchronizers. A sequencer then handles each access. For a read, it looks the word up in a backing memory with one cycle of latency and drives it onto the data bus until the enable goes away.

A programmable mask/match pair reserves a window of addresses for messages from the processor to a companion controller. The socket has no write strobe, so any access inside the window is treated as a write. The data bus is sampled a fixed number of local clocks after the enable is seen. The block never waits for the enable to deassert, because that edge races with the data going invalid. The sample, together with the offset inside the window, is queued in a small FIFO that the companion drains over a valid/ready stream.

Until the backing memory reports itself loaded, the block never drives the bus. The first few reads after that are redirected to the reset vector words, so the processor starts from a known place whatever address it presents.

Top module: `rom_socket_emu`

## Requirements
- R1: After reset, bus_d_oe is 0, wr_valid is 0 and wr_overflow is 0.
- R2: While mem_ready is 0, bus_d_oe stays 0 for every access.
- R3: Once mem_ready is 1, the first VEC_WORDS reads outside the window return the words at addresses RESET_BASE+0, +1, … in order, whatever address is presented. Dropping mem_ready to 0 re-arms this sequence.
- R4: Every other read outside the window drives bus_d_out with the backing word at the presented address, with bus_d_oe at 1, while the enable stays asserted.
- R5: bus_d_oe falls within one clock after the synchronized enable deasserts, which is at most 3 clocks after bus_oe_n rises.
- R6: An address is in the window when (bus_addr & win_mask) == (win_match & win_mask). The block never drives the bus for an access in the window, whether it is a read or a write.
- R7: A window access whose enable is held pushes one entry. The entry is sampled SAMPLE_DLY clocks after the synchronized enable asserts. wr_offset is bus_addr & ~win_mask and wr_data is the full bus_d_in width, so byte writes arrive with the other lane as driven. Data present before the sample point is ignored.
- R8: A window access whose enable deasserts before the sample point pushes nothing.
- R9: Entries leave in arrival order. An entry is consumed on a clock where wr_valid and wr_ready are both 1. While wr_valid is 1 and wr_ready is 0, wr_offset and wr_data hold steady.
- R10: A push into a full FIFO (FIFO_DEPTH entries) is dropped and sets wr_overflow, which stays at 1 until reset. Entries already queued are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ready | input | 1 | Backing memory loaded |
| win_mask | input | ADDR_W | Address bits compared for the write window |
| win_match | input | ADDR_W | Value the masked address bits must equal |
| bus_addr | input | ADDR_W | Socket address, asynchronous |
| bus_oe_n | input | 1 | Socket output enable, active low, asynchronous |
| bus_d_in | input | DATA_W | Socket data as seen on the pins |
| bus_d_out | output | DATA_W | Data to drive onto the socket |
| bus_d_oe | output | 1 | Enable for the socket data drivers |
| mem_addr | output | ADDR_W | Backing memory word address |
| mem_rdata | input | DATA_W | Backing memory word, valid one clock after mem_addr |
| wr_valid | output | 1 | Captured write entry available |
| wr_ready | input | 1 | Companion accepts the entry |
| wr_offset | output | ADDR_W | Offset of the captured write inside the window |
| wr_data | output | DATA_W | Captured write data |
| wr_overflow | output | 1 | Sticky: a captured write was dropped |

## Verification
On every cycle, the assertions check four things. The drivers fall one clock after the synchronized enable goes high, and they stay off while the memory is not ready or an access is in the window. A push into a full queue raises the sticky overflow flag, which never clears by itself. An entry that is stalled keeps its contents. Only the bench's scenarios can show the rest: the order of the vector redirection and its re-arming, the read data across a sweep of addresses, and the offsets and data captured under two window configurations with garbage on the bus before the sample point. They also cover aborted short accesses and the drop-on-full behaviour.

// File: rtl/rse_pkg.sv
package rse_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DRIVE,
    S_WCOUNT,
    S_HOLD
  } seq_state_e;
endpackage

// File: rtl/rse_sync.sv
module rse_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= INIT;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rse_seq.sv
module rse_seq
  import rse_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int SAMPLE_DLY = 6,
  parameter int VEC_WORDS  = 4,
  parameter int RESET_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic              oe_s_n,
  input  logic [DATA_W-1:0] data_s,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [ADDR_W-1:0] win_match,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic              push,
  output logic [ADDR_W-1:0] push_off,
  output logic [DATA_W-1:0] push_data
);
  localparam int CW  = $clog2(SAMPLE_DLY + 1);
  localparam int VCW = $clog2(VEC_WORDS + 2);

  seq_state_e     state;
  logic [CW-1:0]  cnt;
  logic [VCW-1:0] vec_cnt;
  logic           in_win;

  assign in_win = ((addr_s & win_mask) == (win_match & win_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      vec_cnt   <= '0;
      mem_addr  <= '0;
      bus_d_out <= '0;
      bus_d_oe  <= 1'b0;
      push      <= 1'b0;
      push_off  <= '0;
      push_data <= '0;
    end else begin
      push <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (!oe_s_n) begin
            if (in_win) begin
              push_off <= addr_s & ~win_mask;
              cnt      <= '0;
              state    <= S_WCOUNT;
            end else if (mem_ready) begin
              if (vec_cnt < VCW'(VEC_WORDS)) begin
                mem_addr <= ADDR_W'(RESET_BASE) + ADDR_W'(vec_cnt);
                vec_cnt  <= vec_cnt + 1'b1;
              end else begin
                mem_addr <= addr_s;
              end
              state <= S_FETCH;
            end else begin
              state <= S_HOLD;
            end
          end
        end
        S_FETCH: begin
          if (oe_s_n) begin
            state <= S_IDLE;
          end else if (!mem_ready) begin
            state <= S_HOLD;
          end else begin
            bus_d_out <= mem_rdata;
            bus_d_oe  <= 1'b1;
            state     <= S_DRIVE;
          end
        end
        S_DRIVE: begin
          if (oe_s_n || !mem_ready) begin
            bus_d_oe <= 1'b0;
            state    <= oe_s_n ? S_IDLE : S_HOLD;
          end
        end
        S_WCOUNT: begin
          if (oe_s_n) begin
            state <= S_IDLE;
          end else if (cnt == CW'(SAMPLE_DLY - 1)) begin
            push      <= 1'b1;
            push_data <= data_s;
            state     <= S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          bus_d_oe <= 1'b0;
          if (oe_s_n) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (!mem_ready) vec_cnt <= '0;
    end
  end

  // R5: drivers come off one clock after the synchronized enable deasserts
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_s_n |=> !bus_d_oe);

  // R2: no drive while the backing memory is not ready
  assert_no_drive_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |=> !bus_d_oe);

  // R6: window accesses never drive the bus
  assert_window_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WCOUNT) |-> !bus_d_oe);

  // R7: a capture only happens while the enable is still held
  assert_push_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(!oe_s_n));
endmodule

// File: rtl/rse_fifo.sv
module rse_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_d,
  output logic         overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] count;
  logic          full, pop, do_push;

  assign full      = (count == NW'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign do_push   = push && !full;
  assign out_d     = store[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (do_push) begin
        store[wp] <= push_d;
        wp        <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      if (do_push && !pop)      count <= count + 1'b1;
      else if (!do_push && pop) count <= count - 1'b1;
      if (push && full) overflow <= 1'b1;
    end
  end

  // R10: a push into a full queue raises the flag
  assert_drop_on_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow);

  // R10: the flag is sticky
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: a stalled entry stays put
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_d)));

  // R10: occupancy never exceeds the depth
  assert_no_overfill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));
endmodule

// File: rtl/rom_socket_emu.sv
module rom_socket_emu #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int SAMPLE_DLY = 6,
  parameter int VEC_WORDS  = 4,
  parameter int RESET_BASE = 0,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [ADDR_W-1:0] win_match,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_oe_n,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_offset,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_overflow
);
  localparam int EW = ADDR_W + DATA_W;

  logic [ADDR_W-1:0] addr_s;
  logic              oe_s_n;
  logic [DATA_W-1:0] data_s;
  logic              push;
  logic [ADDR_W-1:0] push_off;
  logic [DATA_W-1:0] push_data;
  logic [EW-1:0]     fifo_out;

  rse_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(bus_addr), .q(addr_s));

  rse_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_oe (
    .clk(clk), .rst_n(rst_n), .d(bus_oe_n), .q(oe_s_n));

  rse_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_d_in), .q(data_s));

  rse_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_DLY(SAMPLE_DLY),
    .VEC_WORDS(VEC_WORDS), .RESET_BASE(RESET_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .addr_s(addr_s), .oe_s_n(oe_s_n), .data_s(data_s),
    .mem_ready(mem_ready), .win_mask(win_mask), .win_match(win_match),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .push(push), .push_off(push_off), .push_data(push_data));

  rse_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_d({push_off, push_data}),
    .out_valid(wr_valid), .out_ready(wr_ready), .out_d(fifo_out),
    .overflow(wr_overflow));

  assign wr_offset = fifo_out[EW-1:DATA_W];
  assign wr_data   = fifo_out[DATA_W-1:0];
endmodule

// File: tb/tb_rom_socket_emu.sv
module tb_rom_socket_emu;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DLY = 6;
  localparam int VEC = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_ready = 1'b0;
  logic [AW-1:0] win_mask = 10'h3C0, win_match = 10'h3C0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_oe_n = 1'b1;
  logic [DW-1:0] bus_d_in = '0;
  logic [DW-1:0] bus_d_out;
  logic bus_d_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [AW-1:0] wr_offset;
  logic [DW-1:0] wr_data;
  logic wr_overflow;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, 8'(a >> 2) + 8'h13};
  endfunction

  assign mem_rdata = memf(mem_addr);

  rom_socket_emu #(.ADDR_W(AW), .DATA_W(DW), .SAMPLE_DLY(DLY),
    .VEC_WORDS(VEC), .RESET_BASE(0), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready),
    .win_mask(win_mask), .win_match(win_match),
    .bus_addr(bus_addr), .bus_oe_n(bus_oe_n), .bus_d_in(bus_d_in),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_offset(wr_offset), .wr_data(wr_data), .wr_overflow(wr_overflow));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read access; checks drive data and release timing
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                    input bit expect_drive, input string req);
    bus_addr = a;
    bus_oe_n = 1'b0;
    idle(8);
    if (expect_drive) begin
      chk(bus_d_oe === 1'b1, req, 32'(bus_d_oe), 32'd1);
      chk(bus_d_out === exp, req, 32'(bus_d_out), 32'(exp));
    end else begin
      chk(bus_d_oe === 1'b0, req, 32'(bus_d_oe), 32'd0);
    end
    bus_oe_n = 1'b1;
    idle(3);
    chk(bus_d_oe === 1'b0, "R5", 32'(bus_d_oe), 32'd0);
    idle(2);
  endtask

  // write access with garbage first, real data after two clocks
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold);
    bus_addr = a;
    bus_oe_n = 1'b0;
    bus_d_in = ~d ^ 16'h0F0F;
    idle(2);
    if (hold > 2) bus_d_in = d;
    idle(hold > 2 ? hold - 2 : 0);
    chk(bus_d_oe === 1'b0, "R6", 32'(bus_d_oe), 32'd0);
    bus_oe_n = 1'b1;
    bus_d_in = 16'hDEAD;
    idle(5);
  endtask

  task automatic pop_chk(input logic [AW-1:0] off, input logic [DW-1:0] d,
                         input string req);
    chk(wr_valid === 1'b1, req, 32'(wr_valid), 32'd1);
    chk(wr_offset === off, req, 32'(wr_offset), 32'(off));
    chk(wr_data === d, req, 32'(wr_data), 32'(d));
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
  endtask

  initial begin
    idle(3);
    chk(bus_d_oe === 1'b0, "R1", 32'(bus_d_oe), 32'd0);
    chk(wr_valid === 1'b0, "R1", 32'(wr_valid), 32'd0);
    chk(wr_overflow === 1'b0, "R1", 32'(wr_overflow), 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R2: no drive before the memory is ready
    rd(10'h012, '0, 1'b0, "R2");
    rd(10'h200, '0, 1'b0, "R2");

    mem_ready = 1'b1;
    idle(2);
    // R3: vector words regardless of presented address
    for (int k = 0; k < VEC; k++) rd(AW'(10'h155 + k * 37), memf(AW'(k)), 1'b1, "R3");

    // R4: address sweep outside the window
    for (int a = 0; a < 'h3C0; a += 5) rd(AW'(a), memf(AW'(a)), 1'b1, "R4");

    // R7: captures across the window, drained one by one
    for (int k = 0; k < 16; k++) begin
      wr(AW'('h3C0 + k * 4), DW'(k * 16'h1111) ^ 16'hBEEF, 14);
      pop_chk(AW'(k * 4), DW'(k * 16'h1111) ^ 16'hBEEF, "R7");
    end
    chk(wr_valid === 1'b0, "R9", 32'(wr_valid), 32'd0);

    // R8: short window accesses push nothing
    wr(10'h3C8, 16'h1234, 4);
    wr(10'h3D0, 16'h5678, 3);
    idle(3);
    chk(wr_valid === 1'b0, "R8", 32'(wr_valid), 32'd0);

    // R6: a read in the window is not driven but is captured
    bus_d_in = 16'hA0A0;
    rd(10'h3E1, '0, 1'b0, "R6");
    pop_chk(10'h021, 16'hA0A0, "R6");

    // R9 and R10: fill, stall, overflow
    for (int k = 0; k < DEPTH + 1; k++) wr(AW'('h3C0 + k), DW'(16'h7000 + k), 14);
    chk(wr_overflow === 1'b1, "R10", 32'(wr_overflow), 32'd1);
    idle(4);
    chk(wr_valid === 1'b1 && wr_data === 16'h7000, "R9", 32'(wr_data), 32'h7000);
    for (int k = 0; k < DEPTH; k++) pop_chk(AW'(k), DW'(16'h7000 + k), "R10");
    chk(wr_valid === 1'b0, "R10", 32'(wr_valid), 32'd0);
    chk(wr_overflow === 1'b1, "R10", 32'(wr_overflow), 32'd1);

    // R6/R7: second window configuration
    win_mask = 10'h300;
    win_match = 10'h100;
    idle(2);
    wr(10'h1AB, 16'hC3C3, 14);
    pop_chk(10'h0AB, 16'hC3C3, "R7");
    rd(10'h3C5, memf(10'h3C5), 1'b1, "R6");
    rd(10'h150, '0, 1'b0, "R6");
    pop_chk(10'h050, 16'hDEAD, "R6");

    // R3: re-arm after ready drops
    mem_ready = 1'b0;
    idle(3);
    mem_ready = 1'b1;
    idle(2);
    rd(10'h2A2, memf(10'h000), 1'b1, "R3");
    rd(10'h2A2, memf(10'h001), 1'b1, "R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule